// File: doc/BRIEF.md
# Dual-Channel Result Output Port

This block is the digital output side of a two-channel simultaneous-sampling converter. It holds the latest pair of 16-bit results, channel A and channel B, and hands them to a host in one of two ways. With the serial-mode input low the host reads a parallel bus. A chip select and a read strobe gate the bus. A channel-select pin picks which result is read, and a byte-order pin can exchange the two bytes of the word.

With the serial-mode input high, each new pair of results is loaded into a 32-bit frame and sent MSB first on one data line. The clock-source pin picks the shift clock. In internal (master) mode the block makes its own serial clock and drives it out. In external (slave) mode it shifts on the falling edges of a host clock, which passes through a synchronizer first. A two-bit divide setting slows the master clock, but only when the read-after-convert option is also selected. A busy flag covers each frame.

Top module: `dcop_port`

## Requirements
- R1: After reset, busy, sclk_out, sdout and bus_oe are all low.
- R2: bus_oe is high exactly while ser_mode=0, cs_n=0 and rd_n=0. While bus_oe is low, bus_d reads zero.
- R3: In a parallel read, ch_sel=1 returns the held channel A result and ch_sel=0 returns the held channel B result.
- R4: In a parallel read, byte_swap=0 puts the low result byte on bus_d[7:0] and the high byte on bus_d[15:8]. byte_swap=1 exchanges the two bytes.
- R5: A res_valid pulse with ser_mode=1 loads a 32-bit frame, which is sent MSB first. If ch_sel=1 at load, channel A goes first and then channel B; if ch_sel=0, channel B goes first. The first bit appears on sdout in the cycle after the load.
- R6: In master mode (ext_clk=0 at load), sclk_out stays low when idle. Its half period is 2^div_sel clock cycles when rd_after_cnv=1. Its first rise comes one half period after the load. sdout changes only together with a falling edge of sclk_out.
- R7: In master mode with rd_after_cnv=0, div_sel has no effect and the half period of sclk_out is one clock cycle.
- R8: busy rises in the cycle after a serial load. It falls on the 32nd falling serial clock edge, and sclk_out is low from that point on.
- R9: In slave mode (ext_clk=1 at load), each falling edge of sclk_in advances sdout by one bit once it has passed a two-flop synchronizer, provided busy is high and cs_n is low. Edges that arrive while idle or while cs_n is high are ignored. sclk_out stays low.
- R10: A res_valid pulse with ser_mode=0 updates the held results for parallel reads and leaves busy low.
- R11: A serial load during a frame abandons that frame and starts a full new frame from the new results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| res_valid | input | 1 | One-cycle pulse: new result pair present |
| res_a | input | 16 | Channel A result |
| res_b | input | 16 | Channel B result |
| ser_mode | input | 1 | 1 selects serial output, 0 selects parallel |
| byte_swap | input | 1 | Parallel byte order |
| ch_sel | input | 1 | Channel for parallel read / first channel for serial |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| ext_clk | input | 1 | 1 selects external serial clock, 0 internal |
| rd_after_cnv | input | 1 | Read-after-convert option (enables divider) |
| div_sel | input | 2 | Master clock divide setting |
| sclk_in | input | 1 | External serial clock |
| bus_d | output | 16 | Parallel data |
| bus_oe | output | 1 | Drive enable of the parallel bus (tri-state control) |
| sdout | output | 1 | Serial data |
| sclk_out | output | 1 | Internal serial clock output |
| busy | output | 1 | Serial frame in progress |

## Verification
The assertions run on every cycle. They check that busy only rises after a serial load, and that the internal clock is low whenever the block is idle. They also check that sdout holds steady between shift events and stays steady while a slave frame is deselected, and that every frame ends after exactly 32 shifts. The bench scenarios are needed to show the rest: the actual bit order and channel order, the serial clock period for each divide setting, the divider being ignored without read-after-convert, the byte and channel selection on the bus, and a frame restart.

// File: rtl/dcop_pkg.sv
package dcop_pkg;

  typedef enum logic {CK_INT = 1'b0, CK_EXT = 1'b1} ck_src_e;

  // Half period of the internal serial clock, in block clock cycles.
  function automatic int unsigned half_len(input int unsigned div, input bit scaled);
    return scaled ? (32'd1 << div) : 32'd1;
  endfunction

  // Frame word: the selected first channel occupies the upper half.
  function automatic logic [31:0] frame16(input logic [15:0] a, input logic [15:0] b,
                                          input logic a_first);
    return a_first ? {a, b} : {b, a};
  endfunction

endpackage

// File: rtl/dcop_par_bus.sv
module dcop_par_bus #(
  parameter int RES_W = 16
) (
  input  logic [RES_W-1:0] res_a,
  input  logic [RES_W-1:0] res_b,
  input  logic             ser_mode,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             byte_swap,
  input  logic             ch_sel,
  output logic [RES_W-1:0] bus_d,
  output logic             bus_oe
);
  localparam int NBYTE = RES_W / 8;

  logic [RES_W-1:0] pick;
  logic [RES_W-1:0] swapped;

  assign pick = ch_sel ? res_a : res_b;

  // Reverse the byte order of the selected word.
  generate
    for (genvar g = 0; g < NBYTE; g++) begin : g_byte
      assign swapped[g*8 +: 8] = pick[(NBYTE-1-g)*8 +: 8];
    end
  endgenerate

  assign bus_oe = !ser_mode && !cs_n && !rd_n;
  assign bus_d  = bus_oe ? (byte_swap ? swapped : pick) : '0;

endmodule

// File: rtl/dcop_sclk_gen.sv
module dcop_sclk_gen #(
  parameter int HCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [HCNT_W-1:0] half,
  output logic              sclk_m,
  output logic              rise_ev,
  output logic              fall_ev
);
  logic [HCNT_W-1:0] cnt;
  logic              wrap;

  assign wrap    = run && !restart && (cnt == half - 1'b1);
  assign rise_ev = wrap && !sclk_m;
  assign fall_ev = wrap && sclk_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sclk_m <= 1'b0;
    end else if (restart || !run) begin
      cnt    <= '0;
      sclk_m <= 1'b0;
    end else if (wrap) begin
      cnt    <= '0;
      sclk_m <= ~sclk_m;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: the clock only falls from high, and only rises from low
  a_r6_edge_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> sclk_m);

endmodule

// File: rtl/dcop_edge_sync.sv
module dcop_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall_ev
);
  logic [STAGES-1:0] sr;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      prev <= 1'b0;
    end else begin
      sr   <= {sr[STAGES-2:0], async_in};
      prev <= sr[STAGES-1];
    end
  end

  assign fall_ev = prev && !sr[STAGES-1];

endmodule

// File: rtl/dcop_ser_shift.sv
module dcop_ser_shift #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             a_first,
  input  logic [RES_W-1:0] res_a,
  input  logic [RES_W-1:0] res_b,
  input  logic             shift_ev,
  output logic             sdout,
  output logic             busy,
  output logic             last_ev
);
  localparam int FRAME = 2 * RES_W;
  localparam int CW    = $clog2(FRAME + 1);

  logic [FRAME-1:0] sh;
  logic [CW-1:0]    sent;

  assign last_ev = busy && shift_ev && !load && (sent == CW'(FRAME - 1));
  assign sdout   = busy && sh[FRAME-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      sent <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sh   <= a_first ? {res_a, res_b} : {res_b, res_a};
      sent <= '0;
      busy <= 1'b1;
    end else if (busy && shift_ev) begin
      sh   <= sh << 1;
      sent <= sent + 1'b1;
      if (last_ev) busy <= 1'b0;
    end
  end

  // R6: data holds between shift events
  a_r6_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !shift_ev && !load) |=> (busy && sdout == $past(sdout)));

endmodule

// File: rtl/dcop_port.sv
module dcop_port #(
  parameter int RES_W       = 16,
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_a,
  input  logic [RES_W-1:0] res_b,
  input  logic             ser_mode,
  input  logic             byte_swap,
  input  logic             ch_sel,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             ext_clk,
  input  logic             rd_after_cnv,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             sclk_in,
  output logic [RES_W-1:0] bus_d,
  output logic             bus_oe,
  output logic             sdout,
  output logic             sclk_out,
  output logic             busy
);
  import dcop_pkg::*;

  localparam int MAX_SH = (1 << DIV_W) - 1;
  localparam int HCNT_W = MAX_SH + 1;
  localparam int FRAME  = 2 * RES_W;
  localparam int CW     = $clog2(FRAME + 1);

  logic [RES_W-1:0]  a_q, b_q;
  logic              load;
  ck_src_e           src_q;
  logic [HCNT_W-1:0] half_q;
  logic              sclk_m, m_rise, m_fall;
  logic              s_fall, slave_ev, shift_ev, last_ev;

  assign load = res_valid && ser_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      src_q  <= CK_INT;
      half_q <= HCNT_W'(1);
    end else begin
      if (res_valid) begin
        a_q <= res_a;
        b_q <= res_b;
      end
      if (load) begin
        src_q  <= ext_clk ? CK_EXT : CK_INT;
        half_q <= HCNT_W'(half_len(int'(div_sel), !ext_clk && rd_after_cnv));
      end
    end
  end

  dcop_par_bus #(.RES_W(RES_W)) u_par (
    .res_a(a_q), .res_b(b_q), .ser_mode(ser_mode), .cs_n(cs_n), .rd_n(rd_n),
    .byte_swap(byte_swap), .ch_sel(ch_sel), .bus_d(bus_d), .bus_oe(bus_oe)
  );

  dcop_sclk_gen #(.HCNT_W(HCNT_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(busy && src_q == CK_INT), .restart(load),
    .half(half_q), .sclk_m(sclk_m), .rise_ev(m_rise), .fall_ev(m_fall)
  );

  dcop_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sclk_in), .fall_ev(s_fall)
  );

  assign slave_ev = s_fall && busy && src_q == CK_EXT && !cs_n;
  assign shift_ev = (src_q == CK_EXT) ? slave_ev : m_fall;

  dcop_ser_shift #(.RES_W(RES_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .a_first(ch_sel),
    .res_a(res_a), .res_b(res_b), .shift_ev(shift_ev),
    .sdout(sdout), .busy(busy), .last_ev(last_ev)
  );

  assign sclk_out = busy && src_q == CK_INT && sclk_m;

  // Checker counter: shifts seen in the current frame
  logic [CW-1:0] chk_shifts;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                chk_shifts <= '0;
    else if (load)             chk_shifts <= '0;
    else if (busy && shift_ev) chk_shifts <= chk_shifts + 1'b1;
  end

  // R8: busy only starts from a serial load
  a_r8_busy_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(load));

  // R8: the internal clock rests low whenever no frame runs
  a_r8_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk_m);

  // R5: a frame ends only after all of its bits were shifted
  a_r5_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (chk_shifts == CW'(FRAME)));

  // R9: a deselected slave frame does not move
  a_r9_deselect_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && src_q == CK_EXT && cs_n && !load) |=> (sdout == $past(sdout)));

endmodule

// File: tb/sim_dcop_port.sv
module sim_dcop_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic [15:0] res_a = '0, res_b = '0;
  logic        ser_mode = 1'b0, byte_swap = 1'b0, ch_sel = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, ext_clk = 1'b0, rd_after_cnv = 1'b0;
  logic [1:0]  div_sel = '0;
  logic        sclk_in = 1'b0;
  logic [15:0] bus_d;
  logic        bus_oe, sdout, sclk_out, busy;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dcop_port u0 (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_a(res_a), .res_b(res_b),
    .ser_mode(ser_mode), .byte_swap(byte_swap), .ch_sel(ch_sel), .cs_n(cs_n),
    .rd_n(rd_n), .ext_clk(ext_clk), .rd_after_cnv(rd_after_cnv), .div_sel(div_sel),
    .sclk_in(sclk_in), .bus_d(bus_d), .bus_oe(bus_oe), .sdout(sdout),
    .sclk_out(sclk_out), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic end_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic pulse_load(input logic [15:0] a, input logic [15:0] b);
    res_a = a; res_b = b; res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  // Master frame: check every cycle against an arithmetic model.
  task automatic run_master(input logic [15:0] a, input logic [15:0] b, input logic ch,
                            input logic [1:0] d, input logic rac, input string req);
    int h;
    logic [31:0] f;
    @(negedge clk);
    ser_mode = 1'b1; ext_clk = 1'b0; ch_sel = ch; div_sel = d; rd_after_cnv = rac;
    pulse_load(a, b);
    h = rac ? (1 << d) : 1;
    f = ch ? {a, b} : {b, a};
    for (int n = 0; n <= 64 * h; n++) begin
      logic eb, es, ed;
      eb = (n < 64 * h);
      es = eb && (((n / h) % 2) == 1);
      ed = 1'b0;
      if (eb) ed = f[31 - n / (2 * h)];
      chk({req, " busy"}, 32'(busy), 32'(eb));
      chk({req, " sclk_out"}, 32'(sclk_out), 32'(es));
      chk({req, " sdout"}, 32'(sdout), 32'(ed));
      @(negedge clk);
    end
  endtask

  task automatic slave_edge(input int wait_c);
    sclk_in = 1'b1;
    repeat (wait_c) @(negedge clk);
    sclk_in = 1'b0;
    repeat (wait_c) @(negedge clk);
  endtask

  task automatic run_slave(input logic [15:0] a, input logic [15:0] b, input logic ch);
    logic [31:0] f;
    @(negedge clk);
    ser_mode = 1'b1; ext_clk = 1'b1; ch_sel = ch; cs_n = 1'b0; div_sel = 2'd3;
    rd_after_cnv = 1'b1;
    pulse_load(a, b);
    f = ch ? {a, b} : {b, a};
    chk("R9 slave busy", 32'(busy), 32'd1);
    for (int k = 0; k < 32; k++) begin
      chk("R9 slave bit", 32'(sdout), 32'(f[31 - k]));
      chk("R9 slave sclk_out low", 32'(sclk_out), 32'd0);
      if (k == 5) begin
        cs_n = 1'b1;
        slave_edge(4);
        slave_edge(4);
        cs_n = 1'b0;
        chk("R9 deselected edges ignored", 32'(sdout), 32'(f[31 - k]));
      end
      slave_edge(4);
    end
    chk("R8 slave busy end", 32'(busy), 32'd0);
    chk("R9 slave sdout idle", 32'(sdout), 32'd0);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    end_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 sclk_out", 32'(sclk_out), 32'd0);
    chk("R1 sdout", 32'(sdout), 32'd0);
    chk("R1 bus_oe", 32'(bus_oe), 32'd0);

    // R10: parallel load leaves busy low
    ser_mode = 1'b0;
    pulse_load(16'hA5C3, 16'h3C5A);
    chk("R10 busy stays low", 32'(busy), 32'd0);
    repeat (3) @(negedge clk);
    chk("R10 busy still low", 32'(busy), 32'd0);

    // R2/R3/R4 sweep over gating, channel and byte order
    for (int v = 0; v < 32; v++) begin
      logic sm, cs, rd, ch, sw, eoe;
      logic [15:0] w, ew;
      sm = v[0]; cs = v[1]; rd = v[2]; ch = v[3]; sw = v[4];
      ser_mode = sm; cs_n = cs; rd_n = rd; ch_sel = ch; byte_swap = sw;
      #2;
      eoe = !sm && !cs && !rd;
      w = ch ? 16'hA5C3 : 16'h3C5A;
      ew = eoe ? (sw ? {w[7:0], w[15:8]} : w) : 16'h0;
      chk("R2 bus_oe", 32'(bus_oe), 32'(eoe));
      chk("R3 R4 bus_d", 32'(bus_d), 32'(ew));
      @(negedge clk);
    end

    // R10: a second parallel load replaces the held values
    ser_mode = 1'b0; cs_n = 1'b0; rd_n = 1'b0; byte_swap = 1'b0;
    pulse_load(16'h8001, 16'h7FFE);
    ch_sel = 1'b1; #2;
    chk("R10 R3 new A", 32'(bus_d), 32'h8001);
    ch_sel = 1'b0; #2;
    chk("R10 R3 new B", 32'(bus_d), 32'h7FFE);
    byte_swap = 1'b1; #2;
    chk("R4 swapped B", 32'(bus_d), 32'hFE7F);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; byte_swap = 1'b0;

    // R5/R6/R8: master frames, every divide setting, both orders
    for (int d = 0; d < 4; d++) begin
      run_master(16'hA5C3, 16'h3C5A, 1'b1, 2'(d), 1'b1, "R5 R6 R8 master");
      run_master(16'h8001, 16'h7FFE, 1'b0, 2'(d), 1'b1, "R5 R6 R8 master");
    end
    // R7: divider ignored without read-after-convert
    run_master(16'h1234, 16'hFEDC, 1'b1, 2'd3, 1'b0, "R7 no divide");
    run_master(16'h1234, 16'hFEDC, 1'b0, 2'd2, 1'b0, "R7 no divide");

    // R11: restart mid-frame
    @(negedge clk);
    ser_mode = 1'b1; ext_clk = 1'b0; ch_sel = 1'b1; div_sel = 2'd1; rd_after_cnv = 1'b1;
    pulse_load(16'hFFFF, 16'hFFFF);
    repeat (37) @(negedge clk);
    run_master(16'h0F0F, 16'hC3A5, 1'b0, 2'd1, 1'b1, "R11 restart");

    // R9: idle edges ignored, then slave frames
    ext_clk = 1'b1; cs_n = 1'b0;
    slave_edge(4);
    slave_edge(4);
    chk("R9 idle edges no busy", 32'(busy), 32'd0);
    run_slave(16'hA5C3, 16'h3C5A, 1'b1);
    run_slave(16'h8001, 16'h7FFE, 1'b0);

    end_run();
  end
endmodule